// File: doc/BRIEF.md
# Flow-Controlled Box Descriptor Builder

This block turns one peripheral transfer request into the command-list words that a box-mode DMA engine runs. A request carries a direction, a memory address, a device address, a byte length, a burst size and a 4-bit rate-control client number. The block covers as many whole bursts as it can with six-word box descriptors. Each box spans up to a capped number of rows, with one burst per row. If bytes are left over, it then writes one four-word single descriptor for them. The final descriptor of the list has its last-command flag set.

Words leave on a valid/ready stream, one 32-bit word per handshake. A counter reports how many descriptors the current request has produced so far. A request with an unsupported burst size or a zero length is refused: an error flag rises for one cycle and no word leaves. The block never produces a box with zero rows. A transfer shorter than one burst therefore yields only the single descriptor.

Top module: `fc_desc_builder`

## Requirements
- R1: A request whose burst is not one of 16, 32, 64, 128, 192 or 256, or whose length is zero, raises `err` for exactly the cycle after acceptance. It emits no word, and `desc_count` reads 0 afterwards.
- R2: A box descriptor is six words: command, source, destination, row length, row count, row offset. The command bits 2:0 read 3. Row length holds the burst in bits 31:16 and 15:0. Row count holds the rows in both halves. Row offset is the burst in bits 15:0 for device-to-memory (`req_dir`=0), and the burst in bits 31:16 for memory-to-device (`req_dir`=1).
- R3: The client number sits in command bits 6:3 when `req_dir`=0 and in bits 10:7 when `req_dir`=1. The other field is zero. This holds for box and single commands alike.
- R4: Rows per box equal the remaining length divided by the burst, capped at `ROW_CAP` (default 65535). After each box, the memory-side address rises and the remainder falls by rows × burst. Boxes repeat while at least one burst remains.
- R5: When the length is below one burst, the list holds only the single descriptor, with no box.
- R6: A single descriptor follows the boxes only when the remainder is nonzero. It is four words: command with bits 2:0 = 0, source, destination, and the remaining length. Its memory-side address is the address after all boxes.
- R7: Command bit 31 is 1 on the final descriptor only. `out_last` marks the final word of the list.
- R8: The device-side address is the same in every descriptor of a request. For `req_dir`=0 it is the source word; for `req_dir`=1 it is the destination word.
- R9: While `out_valid` is high and `out_ready` is low, `out_word`, `out_last` and `out_valid` hold.
- R10: `desc_count` clears when a request is accepted and rises by one as each descriptor's last word is taken.
- R11: `req_ready` is high only while no list is being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this cycle |
| req_dir | input | 1 | 0 device-to-memory, 1 memory-to-device |
| req_mem_addr | input | 32 | Memory-side start address |
| req_dev_addr | input | 32 | Device-side address |
| req_len | input | 32 | Transfer length in bytes |
| req_burst | input | 9 | Burst size in bytes |
| req_client | input | 4 | Rate-control client number |
| out_valid | output | 1 | Descriptor word present |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Descriptor word |
| out_last | output | 1 | Final word of the list |
| err | output | 1 | Request refused (one-cycle pulse) |
| desc_count | output | CNT_W | Descriptors emitted for the current request |

## Verification
The bench aims at the corner cases that break the row arithmetic and the tail.

A length below one burst is the first. A builder that still writes a box here sends a zero-row box ahead of the single descriptor. The second is a length that is an exact multiple of the burst. Here a careless tail check adds an empty single descriptor or leaves the last flag off the final box. The third is a length above `ROW_CAP` bursts. This must split into several boxes with correct address steps, and an uncapped count would overflow the halfword fields. The fourth is the 192-byte burst, which is not a power of two. A shift-only divider gives wrong row counts there.

Refused bursts, zero length and random backpressure are also exercised. They expose words leaking out after a refusal, and words changing while the consumer stalls.

// File: rtl/fc_desc_builder.sv
module fc_desc_builder #(
  parameter int ROW_CAP = 65535,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_dir,
  input  logic [31:0]      req_mem_addr,
  input  logic [31:0]      req_dev_addr,
  input  logic [31:0]      req_len,
  input  logic [8:0]       req_burst,
  input  logic [3:0]       req_client,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_word,
  output logic             out_last,
  output logic             err,
  output logic [CNT_W-1:0] desc_count
);

  localparam logic [15:0] CAP = 16'(ROW_CAP);

  logic             running;
  logic             dir_q;
  logic [31:0]      mem_q, dev_q, rem_q;
  logic [8:0]       burst_q;
  logic [3:0]       client_q;
  logic [2:0]       widx;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;

  function automatic logic burst_ok(input logic [8:0] b);
    case (b)
      9'd16, 9'd32, 9'd64, 9'd128, 9'd192, 9'd256: burst_ok = 1'b1;
      default:                                      burst_ok = 1'b0;
    endcase
  endfunction

  logic [31:0] rows_full;
  always_comb begin
    case (burst_q)
      9'd16:   rows_full = rem_q >> 4;
      9'd32:   rows_full = rem_q >> 5;
      9'd64:   rows_full = rem_q >> 6;
      9'd128:  rows_full = rem_q >> 7;
      9'd192:  rows_full = (rem_q >> 6) / 32'd3;
      default: rows_full = rem_q >> 8;
    endcase
  end

  logic        is_box, box_last, last_desc;
  logic [15:0] rows;
  logic [31:0] step, src, dst, cmd, bw;
  logic [2:0]  last_idx;

  assign is_box    = rem_q >= {23'b0, burst_q};
  assign rows      = (rows_full > {16'b0, CAP}) ? CAP : rows_full[15:0];
  assign step      = {16'b0, rows} * {23'b0, burst_q};
  assign box_last  = is_box && (rem_q == step);
  assign last_desc = !is_box || box_last;
  assign last_idx  = is_box ? 3'd5 : 3'd3;
  assign bw        = {23'b0, burst_q};
  assign src       = dir_q ? mem_q : dev_q;
  assign dst       = dir_q ? dev_q : mem_q;
  assign cmd       = {last_desc, 20'b0,
                      dir_q ? client_q : 4'b0,
                      dir_q ? 4'b0 : client_q,
                      is_box ? 3'd3 : 3'd0};

  always_comb begin
    case (widx)
      3'd0:    out_word = cmd;
      3'd1:    out_word = src;
      3'd2:    out_word = dst;
      3'd3:    out_word = is_box ? ((bw << 16) | bw) : rem_q;
      3'd4:    out_word = {rows, rows};
      default: out_word = dir_q ? (bw << 16) : bw;
    endcase
  end

  assign req_ready  = !running;
  assign out_valid  = running;
  assign out_last   = running && last_desc && (widx == last_idx);
  assign err        = err_q;
  assign desc_count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      dir_q    <= 1'b0;
      mem_q    <= '0;
      dev_q    <= '0;
      rem_q    <= '0;
      burst_q  <= 9'd16;
      client_q <= '0;
      widx     <= '0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (!running) begin
        if (req_valid) begin
          cnt_q <= '0;
          widx  <= '0;
          if (burst_ok(req_burst) && req_len != 0) begin
            running  <= 1'b1;
            dir_q    <= req_dir;
            mem_q    <= req_mem_addr;
            dev_q    <= req_dev_addr;
            rem_q    <= req_len;
            burst_q  <= req_burst;
            client_q <= req_client;
          end else begin
            err_q <= 1'b1;
          end
        end
      end else if (out_ready) begin
        if (widx == last_idx) begin
          widx  <= '0;
          cnt_q <= cnt_q + 1'b1;
          if (last_desc) running <= 1'b0;
          else begin
            rem_q <= rem_q - step;
            mem_q <= mem_q + step;
          end
        end else begin
          widx <= widx + 3'd1;
        end
      end
    end
  end

endmodule

module fc_desc_builder_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_word,
  input logic             out_last,
  input logic             err,
  input logic [CNT_W-1:0] desc_count
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last));

  assert_err_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid && desc_count == '0);

  assert_err_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_last_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !out_valid);

  assert_count_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> desc_count >= $past(desc_count));

  assert_last_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last && out_ready |=> !out_valid);

endmodule

bind fc_desc_builder fc_desc_builder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .out_last(out_last),
  .err(err), .desc_count(desc_count)
);

// File: tb/fc_desc_builder_tb.sv
module fc_desc_builder_tb;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_dir = 0, out_ready = 0;
  logic [31:0] req_mem_addr = 0, req_dev_addr = 0, req_len = 0;
  logic [8:0]  req_burst = 0;
  logic [3:0]  req_client = 0;
  logic        req_ready, out_valid, out_last, err;
  logic [31:0] out_word;
  logic [15:0] desc_count;

  int checks = 0, fails = 0;
  bit finished = 0;
  int unsigned exp_q[$];
  int exp_desc;

  always #4 clk = ~clk;

  fc_desc_builder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dir(req_dir), .req_mem_addr(req_mem_addr), .req_dev_addr(req_dev_addr),
    .req_len(req_len), .req_burst(req_burst), .req_client(req_client),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_last(out_last), .err(err), .desc_count(desc_count)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit legal(input int b);
    return b == 16 || b == 32 || b == 64 || b == 128 || b == 192 || b == 256;
  endfunction

  function automatic void build(input bit dir, input longint mem, input longint dev,
                                input longint len, input int b, input int cl);
    longint rem = len, ma = mem, rows;
    int unsigned cf, c;
    exp_q.delete();
    exp_desc = 0;
    cf = dir ? (cl << 7) : (cl << 3);
    while (rem >= b) begin
      rows = rem / b;
      if (rows > 65535) rows = 65535;
      c = cf | 3;
      if (rem == rows * b) c |= 32'h8000_0000;
      exp_q.push_back(c);
      exp_q.push_back(dir ? 32'(ma) : 32'(dev));
      exp_q.push_back(dir ? 32'(dev) : 32'(ma));
      exp_q.push_back((b << 16) | b);
      exp_q.push_back(32'((rows << 16) | rows));
      exp_q.push_back(dir ? (b << 16) : b);
      exp_desc++;
      ma += rows * b;
      rem -= rows * b;
    end
    if (rem != 0) begin
      exp_q.push_back(cf | 32'h8000_0000);
      exp_q.push_back(dir ? 32'(ma) : 32'(dev));
      exp_q.push_back(dir ? 32'(dev) : 32'(ma));
      exp_q.push_back(32'(rem));
      exp_desc++;
    end
  endfunction

  task automatic run_job(input bit dir, input int unsigned mem, input int unsigned dev,
                         input int unsigned len, input int b, input int cl, input int rdy_pct);
    int got = 0;
    bit held = 0;
    logic [31:0] hw;
    @(negedge clk);
    req_dir = dir; req_mem_addr = mem; req_dev_addr = dev;
    req_len = len; req_burst = 9'(b); req_client = 4'(cl);
    req_valid = 1;
    chk(req_ready == 1, "R11 idle ready", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    if (!legal(b) || len == 0) begin
      chk(err == 1, "R1 err pulse", err, 1);
      chk(out_valid == 0, "R1 no words", out_valid, 0);
      @(negedge clk);
      chk(err == 0 && out_valid == 0 && desc_count == 0, "R1 R10 after refuse",
          {err, out_valid, desc_count}, 0);
      return;
    end
    build(dir, mem, dev, len, b, cl);
    chk(req_ready == 0 && out_valid == 1, "R11 busy", req_ready, 0);
    for (int g = 0; g < 5000; g++) begin
      if (held)
        chk(out_valid && out_word == hw, "R9 hold under stall", out_word, hw);
      out_ready = ($urandom % 100) < rdy_pct;
      held = out_valid && !out_ready;
      hw = out_word;
      if (out_valid && out_ready) begin
        chk(got < exp_q.size() && out_word == exp_q[got],
            $sformatf("R2 R3 R4 R5 R6 R8 word %0d", got), out_word,
            got < exp_q.size() ? exp_q[got] : 0);
        chk(out_last == (got == exp_q.size() - 1), "R7 last marker", out_last,
            got == exp_q.size() - 1);
        got++;
        if (out_last || got > exp_q.size()) break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    out_ready = 0;
    chk(got == exp_q.size(), "R4 R6 word total", got, exp_q.size());
    chk(desc_count == 16'(exp_desc), "R10 descriptor count", desc_count, exp_desc);
    chk(req_ready == 1 && out_valid == 0, "R11 back idle", req_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int bl[6] = '{16, 32, 64, 128, 192, 256};
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && req_ready == 1 && err == 0 && desc_count == 0,
        "R11 reset state", {out_valid, req_ready, err}, 3'b010);
    run_job(0, 32'h1000_0000, 32'h8000_0040, 10, 64, 5, 100);     // R5
    run_job(1, 32'h1000_0000, 32'h8000_0040, 255, 256, 9, 60);    // R5
    run_job(0, 32'h2000_0000, 32'h8000_0010, 512, 128, 3, 70);    // R6 no tail
    run_job(1, 32'h2000_0100, 32'h8000_0010, 500, 192, 12, 50);   // R4 192
    run_job(0, 32'h3000_0000, 32'h8000_0020, 65535*16*2 + 5, 16, 15, 80); // R4 cap
    run_job(1, 32'h3000_0000, 32'h8000_0020, 65535*16, 16, 1, 80);        // R4 cap exact
    run_job(0, 32'h4000_0000, 32'h8000_0000, 100, 100, 2, 100);   // R1 burst
    run_job(1, 32'h4000_0000, 32'h8000_0000, 0, 32, 2, 100);      // R1 zero
    run_job(0, 32'h4000_0000, 32'h8000_0000, 64, 0, 2, 100);      // R1 burst 0
    for (int i = 0; i < 40; i++) begin
      int b = bl[$urandom % 6];
      int unsigned len = 1 + ($urandom % 4000);
      if ($urandom % 8 == 0) b = 8 + ($urandom % 300);
      run_job(1'($urandom), $urandom, $urandom, len, b, $urandom % 16, 30 + $urandom % 71);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule